// File: doc/BRIEF.md
# Packed-Lane Integer Vector Arithmetic Unit

This unit runs integer arithmetic on a 64-bit word that is split into independent lanes. It is meant to sit beside a scalar integer core as a coprocessor. For each operation it takes two 64-bit operands, an operation code, a lane width, a format word and a byte offset. The unit can add, subtract or multiply inside every lane. The lanes are eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The output is either the packed lane vector or one 64-bit scalar that sums all lanes.

The format word sets how each lane result is post-processed: an optional arithmetic right shift, an optional half-LSB rounding before that shift, and optional clamping to the lane's signed range. A sticky flag records that some lane clamped. The byte offset selects a 64-bit window from the two operands joined together, and this window replaces the first operand. That is how data that straddles a word boundary is handled. One result register holds the output, and a valid/ready handshake moves data on both sides.

Top module: `simd_alu_top`

## Requirements
- R1: After reset, out_valid is 0, sat_flag is 0 and in_ready is 1.
- R2: Add (op 0) and subtract (op 1) compute each lane's signed result. When fmt is 0, each lane wraps to its own width, and no carry passes between lanes. Lane width is set by mode: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. Lane i occupies bits [W*i+W-1 : W*i].
- R3: Multiply (op 2) in 8-bit and 16-bit mode returns the low W bits of each lane's signed product when fmt is 0.
- R4: When fmt bit 0 (saturate) is 1, any lane result above the lane's signed maximum is replaced by that maximum. Any result below the signed minimum is replaced by that minimum. Each lane is judged on its own.
- R5: sat_flag is sticky. It goes to 1 in the cycle after a legal operation in which at least one lane clamped, and only reset clears it.
- R6: fmt bits [3:2] give a right shift S from 0 to 3, applied as an arithmetic shift to each full-precision lane result. When fmt bit 1 (round) is 1 and S is greater than 0, 2^(S-1) is added before the shift. Saturation or wrapping is applied after the shift.
- R7: align gives a byte offset k from 0 to 7. The first operand used is bits [127-8k : 64-8k] of {opnd_a, opnd_b}. opnd_b is used unchanged as the second operand.
- R8: When scalar_sel is 1, result is the 64-bit two's-complement sum of all lane results, each sign-extended after formatting.
- R9: The operation is illegal in three cases: op 3, mode 3, or multiply in 32-bit mode. An illegal operation gives result 0 and illegal 1, and it leaves sat_flag unchanged.
- R10: An operation is accepted when in_valid and in_ready are both 1. Its outputs appear on the next cycle with out_valid 1. While out_valid is 1 and out_ready is 0, the outputs hold and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| opnd_a | input | 64 | First operand (before alignment) |
| opnd_b | input | 64 | Second operand |
| op | input | 2 | 0 add, 1 subtract, 2 multiply, 3 reserved |
| mode | input | 2 | 0 eight 8-bit, 1 four 16-bit, 2 two 32-bit, 3 reserved |
| fmt | input | 4 | [0] saturate, [1] round, [3:2] right shift |
| align | input | 3 | Byte offset of the first-operand window |
| scalar_sel | input | 1 | 1 returns lane sum, 0 returns packed vector |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 64 | Packed vector or scalar sum |
| illegal | output | 1 | Result came from an illegal operation |
| sat_flag | output | 1 | Sticky lane-clamp indicator |

## Verification
Two cases are hard to reach from the ports. The first is the interaction of rounding, shifting and clamping right at a lane's signed edge, where one step of rounding decides whether a lane clamps. The second is the sticky flag, which must not be set by an illegal operation even when that operation's operands would overflow. Directed cases place lane values exactly at +127/-128 and at odd values with and without rounding. An illegal 32-bit multiply with saturating format is issued before any legal clamp has happened. Several thousand random operations across all modes, offsets and format words, with a fixed seed, cover the rest, and a stalled consumer is held for several cycles while a new operation waits at the input.

// File: rtl/simd_pkg.sv
package simd_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_RSV = 2'd3
    } simd_op_e;

    typedef enum logic [1:0] {
        LM_B8  = 2'd0,
        LM_H16 = 2'd1,
        LM_W32 = 2'd2,
        LM_RSV = 2'd3
    } lane_mode_e;

    typedef struct packed {
        logic [1:0] shift;
        logic       rnd_en;
        logic       sat_en;
    } fmt_t;

    typedef struct packed {
        logic [63:0] data;
        logic        bad;
        logic        clamp;
    } out_word_t;

    localparam int NUM_MODES = 3;

    function automatic logic is_illegal(input simd_op_e o, input lane_mode_e m);
        return (o == OP_RSV) || (m == LM_RSV) || (m == LM_W32 && o == OP_MUL);
    endfunction

    function automatic logic [63:0] lane_sum(input logic [63:0] v, input lane_mode_e m);
        logic [63:0] acc;
        acc = '0;
        case (m)
            LM_B8:  for (int i = 0; i < 8; i++) acc = acc + 64'($signed(v[8*i +: 8]));
            LM_H16: for (int i = 0; i < 4; i++) acc = acc + 64'($signed(v[16*i +: 16]));
            default: for (int i = 0; i < 2; i++) acc = acc + 64'($signed(v[32*i +: 32]));
        endcase
        return acc;
    endfunction

endpackage

// File: rtl/simd_align.sv
module simd_align #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [2:0]    off,
    output logic [DW-1:0] a_win
);
    localparam int CW = 2 * DW;

    logic [CW-1:0] joined;

    always_comb begin
        joined = {a, b};
        a_win  = joined[CW - 1 - 8 * int'(off) -: DW];
    end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  simd_op_e     op,
    input  fmt_t         fmt,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam int XW = 2 * W + 2;
    localparam logic signed [XW-1:0] MAXV = {{(W + 3){1'b0}}, {(W - 1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {{(W + 3){1'b1}}, {(W - 1){1'b0}}};

    logic signed [XW-1:0] ax, bx, raw, half, shifted;
    logic hi, lo;

    always_comb begin
        ax = XW'($signed(a));
        bx = XW'($signed(b));
        case (op)
            OP_ADD:  raw = ax + bx;
            OP_SUB:  raw = ax - bx;
            default: raw = ax * bx;
        endcase
        half = '0;
        if (fmt.rnd_en && fmt.shift != 2'd0) half[fmt.shift - 2'd1] = 1'b1;
        shifted = (raw + half) >>> fmt.shift;
        hi = shifted > MAXV;
        lo = shifted < MINV;
        clamp = fmt.sat_en && (hi || lo);
        if (clamp) res = hi ? MAXV[W-1:0] : MINV[W-1:0];
        else       res = shifted[W-1:0];
    end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int DW = 64,
    parameter int W  = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  simd_op_e      op,
    input  fmt_t          fmt,
    output logic [DW-1:0] res,
    output logic          any_clamp
);
    localparam int NL = DW / W;

    logic [NL-1:0] lane_clamp;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        simd_lane #(.W(W)) u_lane (
            .a     (a[W*i +: W]),
            .b     (b[W*i +: W]),
            .op    (op),
            .fmt   (fmt),
            .res   (res[W*i +: W]),
            .clamp (lane_clamp[i])
        );
    end

    assign any_clamp = |lane_clamp;
endmodule

// File: rtl/simd_alu_top.sv
module simd_alu_top
    import simd_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [1:0]    op,
    input  logic [1:0]    mode,
    input  logic [3:0]    fmt,
    input  logic [2:0]    align,
    input  logic          scalar_sel,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] result,
    output logic          illegal,
    output logic          sat_flag
);
    simd_op_e   op_e;
    lane_mode_e mode_e;
    fmt_t       fmt_s;
    logic [DW-1:0] a_win;
    logic [DW-1:0] bank_res   [NUM_MODES];
    logic          bank_clamp [NUM_MODES];
    out_word_t     nxt, held;
    logic [DW-1:0] vec;
    logic          accept;

    assign op_e   = simd_op_e'(op);
    assign mode_e = lane_mode_e'(mode);
    assign fmt_s  = fmt_t'(fmt);

    simd_align #(.DW(DW)) u_align (
        .a     (opnd_a),
        .b     (opnd_b),
        .off   (align),
        .a_win (a_win)
    );

    for (genvar k = 0; k < NUM_MODES; k++) begin : g_bank
        simd_lane_bank #(.DW(DW), .W(8 << k)) u_bank (
            .a         (a_win),
            .b         (opnd_b),
            .op        (op_e),
            .fmt       (fmt_s),
            .res       (bank_res[k]),
            .any_clamp (bank_clamp[k])
        );
    end

    always_comb begin
        vec       = '0;
        nxt.clamp = 1'b0;
        nxt.bad   = is_illegal(op_e, mode_e);
        if (mode_e != LM_RSV) begin
            vec       = bank_res[mode];
            nxt.clamp = bank_clamp[mode];
        end
        if (nxt.bad) begin
            nxt.data  = '0;
            nxt.clamp = 1'b0;
        end else if (scalar_sel) begin
            nxt.data = lane_sum(vec, mode_e);
        end else begin
            nxt.data = vec;
        end
    end

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            held      <= '0;
            sat_flag  <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            held      <= nxt;
            if (nxt.clamp) sat_flag <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign result  = held.data;
    assign illegal = held.bad;
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] result,
    input logic        illegal,
    input logic        sat_flag
);
    assert_accept_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(result) && $stable(illegal));

    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && illegal |-> result == 64'd0);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        sat_flag |=> sat_flag);
endmodule

bind simd_alu_top simd_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result),
    .illegal   (illegal),
    .sat_flag  (sat_flag)
);

// File: tb/tb_simd_alu_top.sv
module tb_simd_alu_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, out_valid, out_ready;
    logic [63:0] opnd_a, opnd_b, result;
    logic [1:0]  op, mode;
    logic [3:0]  fmt;
    logic [2:0]  align;
    logic        scalar_sel, illegal, sat_flag;

    int checks = 0;
    int failures = 0;
    logic exp_sticky = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    simd_alu_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op(op), .mode(mode), .fmt(fmt),
        .align(align), .scalar_sel(scalar_sel), .out_valid(out_valid),
        .out_ready(out_ready), .result(result), .illegal(illegal), .sat_flag(sat_flag)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model built from R2..R9
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] o,
                         input logic [1:0] m, input logic [3:0] f, input logic [2:0] k,
                         input logic ss, output logic [63:0] r, output logic bad, output logic clp);
        logic [127:0] cat;
        logic [63:0] ae, vec, mask;
        logic signed [67:0] x, y, v, maxv, minv, sum;
        int w, n, sh;
        bad = (o == 2'd3) || (m == 2'd3) || (m == 2'd2 && o == 2'd2);
        clp = 1'b0;
        r = '0;
        if (bad) return;
        cat = {a, b} << (8 * k);
        ae = cat[127:64];
        w = 8 << m;
        n = 64 / w;
        sh = int'(f[3:2]);
        mask = (64'd1 << w) - 64'd1;
        maxv = (68'sd1 <<< (w - 1)) - 68'sd1;
        minv = -(68'sd1 <<< (w - 1));
        vec = '0;
        sum = '0;
        for (int i = 0; i < n; i++) begin
            x = 68'((ae >> (i * w)) & mask);
            y = 68'((b >> (i * w)) & mask);
            if (x[w-1]) x = x - (68'sd1 <<< w);
            if (y[w-1]) y = y - (68'sd1 <<< w);
            v = (o == 2'd0) ? x + y : (o == 2'd1) ? x - y : x * y;
            if (f[1] && sh > 0) v = v + (68'sd1 <<< (sh - 1));
            v = v >>> sh;
            if (f[0] && v > maxv) begin v = maxv; clp = 1'b1; end
            if (f[0] && v < minv) begin v = minv; clp = 1'b1; end
            v = 68'(64'(v) & mask);
            if (v[w-1]) v = v - (68'sd1 <<< w);
            vec = vec | ((64'(v) & mask) << (i * w));
            sum = sum + v;
        end
        r = ss ? sum[63:0] : vec;
    endtask

    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [1:0] o,
                         input logic [1:0] m, input logic [3:0] f, input logic [2:0] k,
                         input logic ss, input string tag);
        logic [63:0] er;
        logic eb, ec;
        model(a, b, o, m, f, k, ss, er, eb, ec);
        @(negedge clk);
        opnd_a = a; opnd_b = b; op = o; mode = m; fmt = f; align = k;
        scalar_sel = ss; in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (ec) exp_sticky = 1'b1;
        check(out_valid === 1'b1, {tag, " R10 out_valid"}, 64'(out_valid), 64'd1);
        check(result === er, {tag, " result"}, result, er);
        check(illegal === eb, {tag, " R9 illegal"}, 64'(illegal), 64'(eb));
        check(sat_flag === exp_sticky, {tag, " R5 sat_flag"}, 64'(sat_flag), 64'(exp_sticky));
    endtask

    initial begin
        #(CLK_NS * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        opnd_a = '0; opnd_b = '0; op = '0; mode = '0; fmt = '0; align = '0; scalar_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        check(sat_flag === 1'b0, "R1 sat_flag", 64'(sat_flag), 64'd0);
        check(in_ready === 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);

        // R2: 8-bit wrap, no carry across lanes
        issue(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 2'd0, 4'h0, 3'd0, 1'b0, "R2 add8 wrap");
        check(result === 64'h8080_8080_8080_8080, "R2 literal", result, 64'h8080_8080_8080_8080);
        issue(64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, 2'd1, 2'd2, 4'h0, 3'd0, 1'b0, "R2 sub32");
        // R9: illegal multiply in 32-bit mode with saturating format, sticky must not rise
        issue(64'h7FFF_FFFF_7FFF_FFFF, 64'h7FFF_FFFF_7FFF_FFFF, 2'd2, 2'd2, 4'h1, 3'd0, 1'b0, "R9 mul32");
        check(sat_flag === 1'b0, "R9 sticky untouched", 64'(sat_flag), 64'd0);
        issue(64'h1234, 64'h1, 2'd3, 2'd0, 4'h0, 3'd0, 1'b0, "R9 op3");
        issue(64'h1234, 64'h1, 2'd0, 2'd3, 4'h0, 3'd0, 1'b1, "R9 mode3");
        // R3: multiply low
        issue(64'h0010_FFFF_0003_7FFF, 64'h0010_FFFF_FFFE_0002, 2'd2, 2'd1, 4'h0, 3'd0, 1'b0, "R3 mul16");
        // R4: clamp
        issue(64'h7F80_0000_0000_7F80, 64'h01FF_0000_0000_0000, 2'd0, 2'd0, 4'h1, 3'd0, 1'b0, "R4 sat8");
        check(result[63:48] === 16'h7F80, "R4 literal lanes", 64'(result[63:48]), 64'h7F80);
        check(sat_flag === 1'b1, "R5 set after clamp", 64'(sat_flag), 64'd1);
        // R6: rounding and scaling
        issue(64'h03, 64'h00, 2'd0, 2'd0, 4'h6, 3'd0, 1'b0, "R6 round");
        check(result[7:0] === 8'h02, "R6 literal round", 64'(result[7:0]), 64'h02);
        issue(64'hFD, 64'h00, 2'd0, 2'd0, 4'h4, 3'd0, 1'b0, "R6 arith");
        check(result[7:0] === 8'hFE, "R6 literal arith", 64'(result[7:0]), 64'hFE);
        // R7: alignment
        issue(64'h1122_3344_5566_7788, 64'h99AA_BBCC_DDEE_FF00, 2'd0, 2'd0, 4'h0, 3'd3, 1'b0, "R7 align3");
        issue(64'h1122_3344_5566_7788, 64'h0, 2'd0, 2'd1, 4'h0, 3'd7, 1'b0, "R7 align7");
        // R8: scalar reduction
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, 2'd0, 4'h0, 3'd0, 1'b1, "R8 sum8");
        check(result === 64'hFFFF_FFFF_FFFF_FFF8, "R8 literal", result, 64'hFFFF_FFFF_FFFF_FFF8);

        // R10: stall
        issue(64'h5, 64'h6, 2'd0, 2'd0, 4'h0, 3'd0, 1'b0, "R10 pre");
        held = result;
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; opnd_a = 64'h1; opnd_b = 64'h1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #1;
            check(result === held, "R10 hold", result, held);
            check(in_ready === 1'b0, "R10 in_ready low", 64'(in_ready), 64'd0);
        end
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        check(result === 64'h2, "R10 after release", result, 64'h2);
        @(posedge clk);
        #1;
        check(out_valid === 1'b0, "R10 drain", 64'(out_valid), 64'd0);

        // Random mix
        for (int t = 0; t < 3000; t++) begin
            issue({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom),
                  4'($urandom), 3'($urandom), 1'($urandom), "R2 R3 R4 R6 R7 R8 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule